// File: doc/BRIEF.md
# Flash Timing Divider and Command Sequencer

This block turns the bus clock into a slow timing tick for nonvolatile-memory program and erase operations, and times each operation as a whole number of those ticks. Software writes a divider value N once after reset. The block accepts that value only if it puts the divided rate inside the allowed 150 kHz to 200 kHz window for the configured bus frequency. From then on a one-cycle tick appears every N+1 bus clocks.

A command is requested with a start strobe and a pulse count P. It is accepted only after the divider has been configured, and only while no operation is running. Once accepted, the block stays busy until it has counted P ticks, then raises done for one cycle. A refused request raises reject for one cycle. An asynchronous reset cuts a running operation short at once and clears the configuration, so the divider has to be written again before any new command.

The sequencer has three states. IDLE waits for work. RUN counts ticks. FINISH is the one-cycle done state. The transitions are IDLE->RUN on an accepted start, RUN->RUN while ticks remain, RUN->FINISH on the counted P-th tick, FINISH->IDLE when no start is present, and FINISH->RUN on an accepted start.

Top module: `flash_tick_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, reject and tick are all 0 and no divider value is held.
- R2: A divider write of value N that is accepted at a clock edge makes tick high for one cycle, first N cycles after that edge, and then every N+1 cycles.
- R3: A divider write is accepted only when BUS_HZ/(N+1) lies in [FMIN_HZ, FMAX_HZ] (N from 39 to 52 with the defaults). Any other value is ignored, which leaves the block unconfigured with no ticks.
- R4: After one write has been accepted, every later divider write is ignored until the next reset, and the tick period stays unchanged.
- R5: A start while unconfigured is refused and busy stays 0.
- R6: A start with P >= 1, while configured and in IDLE or FINISH, is accepted and busy is 1 in the next cycle.
- R7: busy stays 1 until the edge that counts the P-th tick seen in RUN. In the following cycle done is 1 and busy is 0, for exactly one cycle.
- R8: A start in RUN, or a start with P = 0, is refused and has no effect on the running or idle operation.
- R9: reject is 1 for exactly the one cycle that follows the edge at which a refused start was sampled.
- R10: Asserting reset drops busy and done at once, without waiting for a clock. After release, commands are refused again until a new divider write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Divider value N |
| cmd_start | input | 1 | Command request strobe |
| cmd_pulses | input | CNT_W | Operation length in ticks (P) |
| busy | output | 1 | Operation in progress (RUN) |
| done | output | 1 | One-cycle completion pulse (FINISH) |
| reject | output | 1 | One-cycle refusal pulse |
| tick | output | 1 | Divided timing tick |

## Verification
On every cycle, the assertions check the following relations:
- no tick and no busy while unconfigured;
- busy and done never high together;
- done lasts a single cycle and always follows busy;
- reject always follows a start;
- the held divider value never changes once it is set.

Some behaviour only the bench scenarios can show, because it depends on counting across many cycles:
- the exact tick period at both range limits;
- that P ticks elapse before done;
- that out-of-range and repeated writes leave the period untouched;
- that an asynchronous reset in mid-operation clears busy at once and restores the lockout.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ftd_cfg_reg.sv
module ftd_cfg_reg #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DIV_LO = 39,
    parameter int unsigned DIV_HI = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic             cfg_valid,
    output logic [DIV_W-1:0] div_value
);

    logic in_range;

    // R3: only values giving an allowed divided rate are taken
    assign in_range = (32'(wdata) >= DIV_LO) && (32'(wdata) <= DIV_HI);

    // R4: write-once until reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            div_value <= '0;
        end else if (wr && !cfg_valid && in_range) begin
            cfg_valid <= 1'b1;
            div_value <= wdata;
        end
    end

endmodule

// File: rtl/ftd_tick_div.sv
module ftd_tick_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_value,
    output logic             tick
);

    logic [DIV_W-1:0] phase;
    logic             wrap;

    assign wrap = (phase == div_value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!enable || wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = enable && wrap;

endmodule

// File: rtl/ftd_cmd_fsm.sv
module ftd_cmd_fsm
    import ftd_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_pulses,
    output logic             busy,
    output logic             done,
    output logic             reject
);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] seen;
    logic             refuse;
    logic             accept;
    logic             last_tick;

    assign refuse    = cmd_start && (!cfg_valid || (state == ST_RUN) || (cmd_pulses == '0));
    assign accept    = cmd_start && !refuse;
    assign last_tick = tick && (seen == target - 1'b1);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_RUN;
            ST_RUN:    if (last_tick) state_nx = ST_FINISH;
            ST_FINISH: state_nx = accept ? ST_RUN : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register; reset aborts any operation (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target <= '0;
            seen   <= '0;
        end else if (accept) begin
            target <= cmd_pulses;
            seen   <= '0;
        end else if ((state == ST_RUN) && tick) begin
            seen <= seen + 1'b1;
        end
    end

    // R9: registered one-cycle refusal
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reject <= 1'b0;
        end else begin
            reject <= refuse;
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_RUN:    busy = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/flash_tick_sequencer.sv
module flash_tick_sequencer #(
    parameter int unsigned BUS_HZ  = 8_000_000,
    parameter int unsigned FMIN_HZ = 150_000,
    parameter int unsigned FMAX_HZ = 200_000,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_pulses,
    output logic             busy,
    output logic             done,
    output logic             reject,
    output logic             tick
);

    localparam int unsigned DIV_LO = (BUS_HZ + FMAX_HZ - 1) / FMAX_HZ - 1;
    localparam int unsigned DIV_HI = BUS_HZ / FMIN_HZ - 1;

    logic             cfg_valid;
    logic [DIV_W-1:0] div_value;

    ftd_cfg_reg #(
        .DIV_W (DIV_W),
        .DIV_LO(DIV_LO),
        .DIV_HI(DIV_HI)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (div_wr),
        .wdata    (div_wdata),
        .cfg_valid(cfg_valid),
        .div_value(div_value)
    );

    ftd_tick_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_valid),
        .div_value(div_value),
        .tick     (tick)
    );

    ftd_cmd_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .tick      (tick),
        .cmd_start (cmd_start),
        .cmd_pulses(cmd_pulses),
        .busy      (busy),
        .done      (done),
        .reject    (reject)
    );

endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             busy,
    input logic             done,
    input logic             reject,
    input logic             tick,
    input logic             cfg_valid,
    input logic [DIV_W-1:0] div_value
);

    assert_tick_needs_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> !tick);

    assert_write_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_valid && $stable(div_value)));

    assert_no_busy_unconfigured_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> !busy);

    assert_lockout_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cfg_valid) |=> (reject && !busy));

    assert_busy_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_reject_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(cmd_start));

endmodule

bind flash_tick_sequencer ftd_checker #(
    .DIV_W(DIV_W)
) u_ftd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_start(cmd_start),
    .busy     (busy),
    .done     (done),
    .reject   (reject),
    .tick     (tick),
    .cfg_valid(cfg_valid),
    .div_value(div_value)
);

// File: tb/tb_flash_tick_sequencer.sv
module tb_flash_tick_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int BUS_HZ  = 8_000_000;
    localparam int FMIN_HZ = 150_000;
    localparam int FMAX_HZ = 200_000;
    localparam int DIV_W = 8;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             cmd_start = 1'b0;
    logic [CNT_W-1:0] cmd_pulses = '0;
    logic             busy, done, reject, tick;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    flash_tick_sequencer #(
        .BUS_HZ(BUS_HZ), .FMIN_HZ(FMIN_HZ), .FMAX_HZ(FMAX_HZ),
        .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .cmd_start(cmd_start), .cmd_pulses(cmd_pulses),
        .busy(busy), .done(done), .reject(reject), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_cfg;
    int m_div, m_cnt, m_st, m_seen, m_target;
    bit m_rej;

    function automatic bit div_allowed(input int n);
        return ((n + 1) * FMIN_HZ <= BUS_HZ) && ((n + 1) * FMAX_HZ >= BUS_HZ);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 0; m_div = 0; m_cnt = 0; m_st = 0;
            m_seen = 0; m_target = 0; m_rej = 0;
        end else begin
            bit t_now;
            bit took;
            t_now = m_cfg && (m_cnt == m_div);
            took = 0;
            m_rej = 0;
            if (cmd_start) begin
                if (!m_cfg || m_st == 1 || cmd_pulses == 0) m_rej = 1;
                else begin
                    took = 1; m_st = 1; m_target = int'(cmd_pulses); m_seen = 0;
                end
            end
            if (!took) begin
                if (m_st == 1) begin
                    if (t_now) begin
                        m_seen++;
                        if (m_seen == m_target) m_st = 2;
                    end
                end else if (m_st == 2) m_st = 0;
            end
            if (m_cfg) m_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
            else if (div_wr && div_allowed(int'(div_wdata))) begin
                m_cfg = 1; m_div = int'(div_wdata); m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            bit e_tick;
            e_tick = m_cfg && (m_cnt == m_div);
            check(tick === e_tick, "R2 model tick", int'(tick), int'(e_tick));
            check(busy === (m_st == 1), "R7 model busy", int'(busy), int'(m_st == 1));
            check(done === (m_st == 2), "R7 model done", int'(done), int'(m_st == 2));
            check(reject === m_rej, "R9 model reject", int'(reject), int'(m_rej));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_div(input int n);
        div_wr = 1'b1; div_wdata = DIV_W'(n);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic measure_period(output int per);
        int guard = 0;
        while (tick !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
        per = 0;
        do begin @(negedge clk); per++; end while (tick !== 1'b1 && per < 500);
    endtask

    task automatic pulse_start(input int p);
        cmd_start = 1'b1; cmd_pulses = CNT_W'(p);
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done(output int ticks_busy);
        int guard = 0;
        ticks_busy = 0;
        while (done !== 1'b1 && guard < 5000) begin
            if (busy === 1'b1 && tick === 1'b1) ticks_busy++;
            @(negedge clk); guard++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, tb;
        step(3);
        check(!busy && !done && !reject && !tick, "R1 reset quiet", int'({busy,done,reject,tick}), 0);
        rst_n = 1'b1;
        step(1);
        check(!busy && !done && !reject && !tick, "R1 after release", int'({busy,done,reject,tick}), 0);

        // lockout before configuration
        pulse_start(2);
        check(reject === 1'b1 && busy === 1'b0, "R5 start unconfigured refused", int'({reject,busy}), 2);
        step(1);
        check(reject === 1'b0, "R9 reject one cycle", int'(reject), 0);

        // out-of-range writes
        write_div(10);
        write_div(53);
        begin
            int seen_t = 0;
            for (int i = 0; i < 80; i++) begin if (tick === 1'b1) seen_t++; @(negedge clk); end
            check(seen_t == 0, "R3 out-of-range ignored, no ticks", seen_t, 0);
        end
        pulse_start(1);
        check(reject === 1'b1, "R3 still unconfigured", int'(reject), 1);

        // lower boundary value
        write_div(39);
        step(38);
        check(tick === 1'b0, "R2 no tick before N cycles", int'(tick), 0);
        step(1);
        check(tick === 1'b1, "R2 first tick N cycles after write", int'(tick), 1);
        measure_period(per);
        check(per == 40, "R2 period N+1", per, 40);

        // second write ignored
        write_div(45);
        measure_period(per);
        check(per == 40, "R4 second write ignored", per, 40);

        // normal command
        pulse_start(3);
        check(busy === 1'b1, "R6 accepted busy", int'(busy), 1);
        wait_done(tb);
        check(tb == 3, "R7 P ticks before done", tb, 3);
        check(done === 1'b1 && busy === 1'b0, "R7 done state", int'({done,busy}), 2);
        step(1);
        check(done === 1'b0, "R7 done single", int'(done), 0);

        // refused while running
        pulse_start(2);
        step(5);
        pulse_start(7);
        check(reject === 1'b1 && busy === 1'b1, "R8 refused while running", int'({reject,busy}), 3);
        wait_done(tb);
        check(done === 1'b1, "R8 original run completes", int'(done), 1);

        // accept from FINISH (back to back)
        pulse_start(1);
        check(busy === 1'b1 && reject === 1'b0, "R6 accept from FINISH", int'({busy,reject}), 2);
        wait_done(tb);
        check(tb == 1, "R7 single-tick operation", tb, 1);
        step(2);

        // zero count refused
        pulse_start(0);
        check(reject === 1'b1 && busy === 1'b0, "R8 zero count refused", int'({reject,busy}), 2);
        step(1);

        // reset in mid-operation
        pulse_start(4);
        step(20);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check(busy === 1'b0 && done === 1'b0, "R10 immediate abort", int'({busy,done}), 0);
        step(3);
        rst_n = 1'b1;
        step(1);
        pulse_start(1);
        check(reject === 1'b1, "R10 lockout after reset", int'(reject), 1);

        // upper boundary value
        write_div(52);
        measure_period(per);
        check(per == 53, "R3 upper bound accepted, period", per, 53);
        pulse_start(1);
        check(busy === 1'b1, "R6 accept after reconfig", int'(busy), 1);
        wait_done(tb);
        check(tb == 1, "R7 completes after reconfig", tb, 1);
        step(3);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule